// File: doc/BRIEF.md
# Variable-Rate PCM Slot Filler

This block assembles the PCM payload of each outgoing audio-link frame when the codec runs at sample rates below the frame rate. While variable-rate operation is on, the codec sends one request bit per PCM slot in the second slot (slot 1) of every incoming frame. The block keeps those requests and, at the next outgoing frame boundary, grants each slot that was both requested and enabled in the channel assignment mask. For every granted slot it pops exactly one sample from that slot's own FIFO.

When variable-rate operation is off, slot 1 carries no requests, and every enabled slot is served in every frame. A granted slot whose FIFO is empty goes out as zero data with its tag cleared, and a sticky underrun flag is set. The downstream serializer reads one valid tag and one data word per PCM slot. Both are registered and stay stable for the whole frame.

Top module: `vrf_slot_filler`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) all tags are 0, all slot data is 0, the underrun flag is 0, every FIFO is empty and fifo_full is 0.
- R2: While vra_en is 1, a cycle with rx_slot1_vld high captures request bits rx_slot1[11:2]. A request bit is active low (0 means requested). Bit 11 belongs to PCM slot 3 (index 0) and bit 2 belongs to PCM slot 12 (index 9).
- R3: With vra_en at 1, a frame_sync cycle grants exactly the slots that are requested and set in slot_map. The tag and data results appear on the clock edge that samples frame_sync and are held until the next frame_sync.
- R4: Each frame_sync consumes the stored requests. A slot that is not requested again in the following input frame gets no sample in the frame after that.
- R5: With vra_en at 0, every slot set in slot_map is granted at every frame_sync, and rx_slot1 has no effect.
- R6: Each granted slot with a non-empty FIFO outputs tag 1 and pops one sample, in push order. A slot that is not granted outputs tag 0 and data 0, and its FIFO contents stay where they are. Slot i data is slot_data[i*20 +: 20].
- R7: A granted slot with an empty FIFO outputs tag 0 and data 0 and sets the underrun flag. The flag stays set until reset.
- R8: Each slot FIFO holds 4 samples. fifo_full[i] is 1 when the FIFO holds 4 samples, and a push into a full FIFO is dropped.
- R9: If a slot-1 capture and frame_sync fall in the same cycle, that frame uses the earlier requests and the new requests apply to the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vra_en | input | 1 | Variable-rate operation enable |
| slot_map | input | 10 | Slot enable mask, bit i = PCM slot 3+i |
| rx_slot1 | input | 20 | Parsed input-frame slot 1 word |
| rx_slot1_vld | input | 1 | Strobe: rx_slot1 holds a complete slot 1 word |
| frame_sync | input | 1 | Strobe: start of the next output frame |
| push_vld | input | 10 | Per-slot sample push |
| push_data | input | 200 | Per-slot push samples, slot i at [i*20 +: 20] |
| fifo_full | output | 10 | Per-slot FIFO full |
| tag_vld | output | 10 | Per-slot valid tag of the current output frame |
| slot_data | output | 200 | Per-slot output data, slot i at [i*20 +: 20] |
| underrun | output | 1 | Sticky: a granted slot had no sample |

## Verification
Tags, data and the underrun flag change on the same clock edge that samples frame_sync. The bench raises frame_sync at a falling edge, lowers it at the next falling edge and compares the outputs right then, so exactly one rising edge lies between stimulus and check. A push or a slot-1 capture is registered on the rising edge after it is driven, so fifo_full and the stored requests are first visible to a frame that is raised at the following falling edge. The bench's per-slot queue model follows that same order. The same-cycle case in R9 is driven in one falling-edge window and checked across two frames.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
    localparam int unsigned VRF_NSLOT   = 10;  // PCM slots 3..12
    localparam int unsigned VRF_DW      = 20;  // slot width in bits
    localparam int unsigned VRF_DEPTH   = 4;   // samples per slot FIFO
    localparam int unsigned VRF_REQ_MSB = 11;  // request bit of the first PCM slot

    // Index of the slot-1 word bit that carries the request for slot index i.
    function automatic int unsigned vrf_req_bit(input int unsigned msb, input int unsigned i);
        return msb - i;
    endfunction
endpackage

// File: rtl/vrf_slot_fifo.sv
module vrf_slot_fifo #(
    parameter int unsigned DW    = 20,
    parameter int unsigned DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t          s_q, s_d;
    logic [DW-1:0] mem [DEPTH];
    logic          do_push, do_pop;

    assign empty   = (s_q.cnt == '0);
    assign full    = (s_q.cnt == CW'(DEPTH));
    assign head    = mem[s_q.rd];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        s_d = s_q;
        if (do_push) s_d.wr = (s_q.wr == LAST) ? '0 : s_q.wr + 1'b1;
        if (do_pop)  s_d.rd = (s_q.rd == LAST) ? '0 : s_q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[s_q.wr] <= push_data;
    end
endmodule

// File: rtl/vrf_req_capture.sv
module vrf_req_capture
    import vrf_pkg::*;
#(
    parameter int unsigned NSLOT   = 10,
    parameter int unsigned DW      = 20,
    parameter int unsigned REQ_MSB = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vra_en,
    input  logic [DW-1:0]    slot1_word,
    input  logic             slot1_vld,
    input  logic             frame_sync,
    output logic [NSLOT-1:0] req
);
    typedef struct packed {
        logic [NSLOT-1:0] pend;
    } req_st_t;

    req_st_t          r_q, r_d;
    logic [NSLOT-1:0] decoded;

    // Active-low request bits, first PCM slot at the most significant position.
    always_comb begin
        for (int unsigned i = 0; i < NSLOT; i++)
            decoded[i] = ~slot1_word[vrf_req_bit(REQ_MSB, i)];
    end

    always_comb begin
        r_d = r_q;
        if (frame_sync) r_d.pend = '0;           // consumed by this frame
        if (slot1_vld)  r_d.pend = decoded;      // newer requests go to the next frame
        if (!vra_en)    r_d.pend = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req = r_q.pend;
endmodule

// File: rtl/vrf_grant.sv
module vrf_grant #(
    parameter int unsigned NSLOT = 10
) (
    input  logic             vra_en,
    input  logic             frame_sync,
    input  logic [NSLOT-1:0] req,
    input  logic [NSLOT-1:0] slot_map,
    input  logic [NSLOT-1:0] empty,
    output logic [NSLOT-1:0] fill,
    output logic [NSLOT-1:0] starve
);
    logic [NSLOT-1:0] want;

    always_comb begin
        want   = vra_en ? (req & slot_map) : slot_map;
        fill   = frame_sync ? (want & ~empty) : '0;
        starve = frame_sync ? (want & empty)  : '0;
    end
endmodule

// File: rtl/vrf_slot_filler.sv
module vrf_slot_filler
    import vrf_pkg::*;
#(
    parameter int unsigned NUM_SLOTS  = VRF_NSLOT,
    parameter int unsigned DATA_W     = VRF_DW,
    parameter int unsigned FIFO_DEPTH = VRF_DEPTH,
    parameter int unsigned REQ_MSB    = VRF_REQ_MSB
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        vra_en,
    input  logic [NUM_SLOTS-1:0]        slot_map,
    input  logic [DATA_W-1:0]           rx_slot1,
    input  logic                        rx_slot1_vld,
    input  logic                        frame_sync,
    input  logic [NUM_SLOTS-1:0]        push_vld,
    input  logic [NUM_SLOTS*DATA_W-1:0] push_data,
    output logic [NUM_SLOTS-1:0]        fifo_full,
    output logic [NUM_SLOTS-1:0]        tag_vld,
    output logic [NUM_SLOTS*DATA_W-1:0] slot_data,
    output logic                        underrun
);
    localparam int unsigned BUSW = NUM_SLOTS * DATA_W;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] tag;
        logic [BUSW-1:0]      data;
        logic                 ur;
    } frame_st_t;

    frame_st_t            f_q, f_d;
    logic [NUM_SLOTS-1:0] req, fill, starve, empty;
    logic [BUSW-1:0]      heads;

    vrf_req_capture #(
        .NSLOT(NUM_SLOTS), .DW(DATA_W), .REQ_MSB(REQ_MSB)
    ) u_req (
        .clk(clk), .rst_n(rst_n), .vra_en(vra_en),
        .slot1_word(rx_slot1), .slot1_vld(rx_slot1_vld),
        .frame_sync(frame_sync), .req(req)
    );

    vrf_grant #(.NSLOT(NUM_SLOTS)) u_grant (
        .vra_en(vra_en), .frame_sync(frame_sync), .req(req),
        .slot_map(slot_map), .empty(empty), .fill(fill), .starve(starve)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_fifo
        vrf_slot_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(push_vld[g]), .push_data(push_data[g*DATA_W +: DATA_W]),
            .pop(fill[g]), .head(heads[g*DATA_W +: DATA_W]),
            .empty(empty[g]), .full(fifo_full[g])
        );
    end

    always_comb begin
        f_d = f_q;
        if (frame_sync) begin
            f_d.tag = fill;
            for (int unsigned i = 0; i < NUM_SLOTS; i++)
                f_d.data[i*DATA_W +: DATA_W] = fill[i] ? heads[i*DATA_W +: DATA_W] : '0;
        end
        f_d.ur = f_q.ur | (|starve);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign tag_vld   = f_q.tag;
    assign slot_data = f_q.data;
    assign underrun  = f_q.ur;
endmodule

// File: rtl/vrf_slot_filler_chk.sv
module vrf_slot_filler_chk #(
    parameter int unsigned NSLOT = 10,
    parameter int unsigned DW    = 20
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  vra_en,
    input logic [NSLOT-1:0]      slot_map,
    input logic                  frame_sync,
    input logic [NSLOT-1:0]      fifo_full,
    input logic [NSLOT-1:0]      tag_vld,
    input logic [NSLOT*DW-1:0]   slot_data,
    input logic                  underrun
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (tag_vld == '0 && slot_data == '0 && !underrun && fifo_full == '0));

    assert_tag_within_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> ((tag_vld & ~$past(slot_map)) == '0));

    assert_hold_between_syncs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !frame_sync) |=> ($stable(tag_vld) && $stable(slot_data)));

    assert_fixed_rate_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && !vra_en && !underrun) |=> (underrun || tag_vld == $past(slot_map)));

    assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    for (genvar g = 0; g < NSLOT; g++) begin : g_idle
        assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !tag_vld[g] |-> (slot_data[g*DW +: DW] == '0));
    end
endmodule

bind vrf_slot_filler vrf_slot_filler_chk #(.NSLOT(NUM_SLOTS), .DW(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .vra_en(vra_en), .slot_map(slot_map),
    .frame_sync(frame_sync), .fifo_full(fifo_full), .tag_vld(tag_vld),
    .slot_data(slot_data), .underrun(underrun)
);

// File: tb/sim_vrf_slot_filler.sv
`timescale 1ns/1ps
module sim_vrf_slot_filler;
    localparam int NS = 10;
    localparam int DW = 20;
    localparam int DEPTH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            vra_en = 1'b0;
    logic [NS-1:0]   slot_map = '0;
    logic [DW-1:0]   rx_slot1 = '0;
    logic            rx_slot1_vld = 1'b0;
    logic            frame_sync = 1'b0;
    logic [NS-1:0]   push_vld = '0;
    logic [NS*DW-1:0] push_data = '0;
    logic [NS-1:0]   fifo_full;
    logic [NS-1:0]   tag_vld;
    logic [NS*DW-1:0] slot_data;
    logic            underrun;

    always #4 clk = ~clk;  // 125 MHz

    vrf_slot_filler u0 (
        .clk(clk), .rst_n(rst_n), .vra_en(vra_en), .slot_map(slot_map),
        .rx_slot1(rx_slot1), .rx_slot1_vld(rx_slot1_vld), .frame_sync(frame_sync),
        .push_vld(push_vld), .push_data(push_data), .fifo_full(fifo_full),
        .tag_vld(tag_vld), .slot_data(slot_data), .underrun(underrun)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Bench model: per-slot queues, pending requests, sticky underrun.
    logic [DW-1:0] mq [NS][$];
    logic [NS-1:0] req_m = '0;
    logic          ur_m = 1'b0;

    typedef struct packed {
        logic          vra;
        logic [NS-1:0] map;
        logic [NS-1:0] req_n;   // bit i = slot index i, active low
        logic [NS-1:0] push;
        logic [NS-1:0] grant;   // expected grant before FIFO emptiness
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 10'h3FF, 10'h3FE, 10'h3FF, 10'h001},
        '{1'b1, 10'h3FF, 10'h000, 10'h001, 10'h3FF},
        '{1'b1, 10'h00F, 10'h000, 10'h3FF, 10'h00F},
        '{1'b1, 10'h3F0, 10'h0FF, 10'h000, 10'h300},
        '{1'b0, 10'h155, 10'h3FF, 10'h155, 10'h155},
        '{1'b0, 10'h2AA, 10'h000, 10'h2AA, 10'h2AA},
        '{1'b1, 10'h3FF, 10'h3FF, 10'h000, 10'h000},
        '{1'b1, 10'h000, 10'h000, 10'h3FF, 10'h000}
    };

    task automatic chk(input string r, input string what, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NS; i++) mq[i].delete();
        req_m = '0;
        ur_m = 1'b0;
    endtask

    task automatic set_mode(input logic vra, input logic [NS-1:0] map);
        @(negedge clk);
        vra_en = vra;
        slot_map = map;
        if (!vra) req_m = '0;
    endtask

    task automatic push_mask(input logic [NS-1:0] m, input logic [DW-1:0] base);
        @(negedge clk);
        push_vld = m;
        for (int i = 0; i < NS; i++) begin
            push_data[i*DW +: DW] = base + DW'(i);
            if (m[i] && mq[i].size() < DEPTH) mq[i].push_back(base + DW'(i));
        end
        @(negedge clk);
        push_vld = '0;
    endtask

    function automatic logic [DW-1:0] req_word(input logic [NS-1:0] rn);
        logic [DW-1:0] w = 20'hFF003;  // bits outside [11:2] are don't-care noise
        for (int i = 0; i < NS; i++) w[11-i] = rn[i];
        return w;
    endfunction

    task automatic send_slot1(input logic [NS-1:0] rn);
        @(negedge clk);
        rx_slot1 = req_word(rn);
        rx_slot1_vld = 1'b1;
        if (vra_en) req_m = ~rn;
        @(negedge clk);
        rx_slot1_vld = 1'b0;
    endtask

    // Expected frame from the model; consumes model requests.
    task automatic expect_frame(input string r, input logic [NS-1:0] grant);
        logic [NS-1:0]    et = '0;
        logic [NS*DW-1:0] ed = '0;
        for (int i = 0; i < NS; i++) begin
            if (grant[i]) begin
                if (mq[i].size() > 0) begin
                    et[i] = 1'b1;
                    ed[i*DW +: DW] = mq[i].pop_front();
                end else begin
                    ur_m = 1'b1;
                end
            end
        end
        chk(r, "tag_vld", 256'(tag_vld), 256'(et));
        chk(r, "slot_data", 256'(slot_data), 256'(ed));
        chk("R7", "underrun", 256'(underrun), 256'(ur_m));
    endtask

    function automatic logic [NS-1:0] model_grant();
        return vra_en ? (req_m & slot_map) : slot_map;
    endfunction

    task automatic frame(input string r);
        logic [NS-1:0] g;
        @(negedge clk);
        g = model_grant();
        req_m = '0;
        frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
        expect_frame(r, g);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1", "tag_vld", 256'(tag_vld), 256'(0));
        chk("R1", "slot_data", 256'(slot_data), 256'(0));
        chk("R1", "underrun", 256'(underrun), 256'(0));
        chk("R1", "fifo_full", 256'(fifo_full), 256'(0));

        // Vector table: R2, R3, R5, R6
        for (int v = 0; v < 8; v++) begin
            set_mode(VECS[v].vra, VECS[v].map);
            push_mask(VECS[v].push, DW'(v * 256));
            send_slot1(VECS[v].req_n);
            chk("R2", "model grant vs table", 256'(model_grant()), 256'(VECS[v].grant));
            frame(VECS[v].vra ? "R3" : "R5");
        end

        // R4: requests are used by one frame only
        do_reset();
        set_mode(1'b1, 10'h3FF);
        push_mask(10'h001, 20'h00A00);
        push_mask(10'h001, 20'h00B00);
        send_slot1(10'h3FE);
        frame("R4");
        frame("R4");
        chk("R4", "slot3 untouched tag", 256'(tag_vld), 256'(0));
        send_slot1(10'h3FE);
        frame("R4");
        chk("R6", "second sample in order", 256'(slot_data[DW-1:0]), 256'(20'h00B00));

        // R7: requested slot with empty FIFO
        send_slot1(10'h3DF);
        frame("R7");
        chk("R7", "underrun set", 256'(underrun), 256'(1));
        push_mask(10'h020, 20'h05500);
        send_slot1(10'h3DF);
        frame("R7");
        chk("R7", "underrun sticky", 256'(underrun), 256'(1));

        // R8: overflow dropped, full flag
        do_reset();
        for (int k = 0; k < 5; k++) begin
            push_mask(10'h004, DW'(k * 16));
            if (k == 2) chk("R8", "not full at 3", 256'(fifo_full), 256'(0));
        end
        chk("R8", "full at 4", 256'(fifo_full), 256'(10'h004));
        set_mode(1'b0, 10'h004);
        for (int k = 0; k < 5; k++) frame("R8");
        chk("R8", "fifo_full after drain", 256'(fifo_full), 256'(0));

        // R9: capture and frame_sync in the same cycle
        do_reset();
        set_mode(1'b1, 10'h3FF);
        push_mask(10'h003, 20'h07700);
        send_slot1(10'h3FE);          // earlier: slot index 0
        begin
            logic [NS-1:0] g;
            @(negedge clk);
            g = model_grant();
            frame_sync = 1'b1;
            rx_slot1 = req_word(10'h3FD);  // newer: slot index 1
            rx_slot1_vld = 1'b1;
            @(negedge clk);
            frame_sync = 1'b0;
            rx_slot1_vld = 1'b0;
            expect_frame("R9", g);
            req_m = 10'h002;
        end
        frame("R9");
        chk("R9", "newer request served next", 256'(tag_vld), 256'(10'h002));

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule